// File: doc/BRIEF.md
# Dual-Loop Frequency Synthesizer Digital Core

This block is the digital half of a two-loop frequency synthesizer for a narrow-band radio: one loop steers the transmit oscillator, the other the receive oscillator. A single 12-bit reference divider turns the crystal clock into the comparison rate used by both loops. Each loop has a 14-bit feedback divider driven by its own oscillator, a tri-state phase-frequency detector that produces up/down correction pulses, a charge-pump strength selection, and a lock monitor.

The crystal and oscillator inputs are clock-enable strobes (`ref_tick`, `tx_vco_tick`, `rx_vco_tick`) sampled on the system clock. Divide ratios, charge-pump strength and power-save bits come in as static parallel values from a register file elsewhere. For example, a 10.24 MHz reference divided by 2048 gives a 5 kHz comparison rate, and a receive ratio of 7183 then sets the receive oscillator to 35.915 MHz. The divided strobes are brought out so that the loop timing can be observed.

Top module: `dual_synth_core`

## Requirements
- R1: With the shared oscillator running, `ref_div_out` is high during exactly every Reff-th cycle in which `ref_tick` is high, where Reff is `ref_ratio` (12 bits, legal 5 to 4095); counting restarts after each strobe and from reset.
- R2: Each feedback divider behaves the same way on its own oscillator strobe, with its 14-bit ratio (legal 5 to 16383), and drives `tx_div_out` / `rx_div_out`.
- R3: Any ratio below 5, including 0, divides by 5.
- R4: A loop's up output goes high in the cycle after a reference strobe and its down output in the cycle after a feedback strobe. Once one of them is high it stays high until the other strobe arrives, and then both return low. A reference strobe and a feedback strobe in the same cycle leave both outputs low.
- R5: The charge-pump current output reads 200 when the loop's strength bit is 0 and 400 when it is 1.
- R6: While a loop's save bit is 1, its feedback divider is held at zero and produces no strobe, its up and down outputs are low, and its lock flag is low. The other loop is not affected.
- R7: `osc_en` is low only when both save bits are 1. While it is low, the reference divider is held at zero and produces no strobe.
- R8: A loop's lock flag rises in the cycle after the 8th consecutive reference strobe whose preceding comparison interval contained no wide pulse.
- R9: A correction pulse (up or down) counts as wide once it reaches 4 cycles. The lock flag is low from the cycle after a pulse's 4th cycle, and the count of R8 starts again.
- R10: A loop's up and down outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Crystal oscillator strobe |
| tx_vco_tick | input | 1 | Transmit oscillator strobe |
| rx_vco_tick | input | 1 | Receive oscillator strobe |
| ref_ratio | input | 12 | Reference divide ratio |
| tx_ratio | input | 14 | Transmit feedback divide ratio |
| rx_ratio | input | 14 | Receive feedback divide ratio |
| tx_cp_hi | input | 1 | Transmit charge-pump strength (1 = double current) |
| rx_cp_hi | input | 1 | Receive charge-pump strength (1 = double current) |
| tx_save | input | 1 | Transmit loop power-save |
| rx_save | input | 1 | Receive loop power-save |
| osc_en | output | 1 | Shared oscillator enable |
| ref_div_out | output | 1 | Divided reference strobe |
| tx_div_out | output | 1 | Divided transmit feedback strobe |
| rx_div_out | output | 1 | Divided receive feedback strobe |
| tx_up | output | 1 | Transmit pump-up pulse |
| tx_dn | output | 1 | Transmit pump-down pulse |
| tx_cp_units | output | 9 | Transmit charge-pump current (200 or 400) |
| tx_lock | output | 1 | Transmit lock flag |
| rx_up | output | 1 | Receive pump-up pulse |
| rx_dn | output | 1 | Receive pump-down pulse |
| rx_cp_units | output | 9 | Receive charge-pump current (200 or 400) |
| rx_lock | output | 1 | Receive lock flag |

## Verification
Random strobes and ratios almost never keep the two divided strobes aligned for eight comparisons in a row, so the lock flag is hard to reach from the ports. The bench therefore resets with every strobe held high and equal ratios, which makes both dividers fire in the same cycles from the start, and counts reference strobes to confirm the exact cycle in which lock rises. It then stops the transmit feedback so that one up pulse grows cycle by cycle. The flag must survive a pulse of three cycles and fall in the cycle after the fourth. Random runs, including ratios below the clamp and random power-save bits, are compared cycle by cycle with a bench model of the dividers and detectors.

// File: rtl/synth_pkg.sv
package synth_pkg;

  localparam int unsigned NUM_LOOPS = 2;
  localparam int unsigned TX_IDX    = 0;
  localparam int unsigned RX_IDX    = 1;
  localparam int unsigned CP_W      = 9;
  localparam int unsigned CP_LOW    = 200;

  typedef logic [CP_W-1:0] cp_amt_t;

  // Effective divide ratio: anything under the floor is raised to the floor.
  function automatic logic [15:0] eff_ratio(input logic [15:0] req, input logic [15:0] floor_v);
    return (req < floor_v) ? floor_v : req;
  endfunction

  // Charge-pump current: the high-strength setting doubles the base current.
  function automatic cp_amt_t cp_amount(input logic hi);
    cp_amt_t base;
    base = cp_amt_t'(CP_LOW);
    return hi ? cp_amt_t'(base << 1) : base;
  endfunction

endpackage

// File: rtl/synth_divider.sv
module synth_divider
  import synth_pkg::*;
#(
  parameter int unsigned W         = 14,
  parameter int unsigned MIN_RATIO = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic [W-1:0] ratio,
  output logic         pulse
);

  logic [W-1:0] cnt;
  logic [15:0]  lim;
  logic         hit;

  assign lim   = eff_ratio(16'(ratio), 16'(MIN_RATIO));
  // A count at or past the limit fires at once, so shrinking the ratio never stalls.
  assign hit   = (16'(cnt) + 16'd1) >= lim;
  assign pulse = en & tick & hit;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (pulse)  cnt <= '0;
    else if (tick)   cnt <= cnt + 1'b1;
  end

  assert_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> (cnt == '0));

  assert_min_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

endmodule

// File: rtl/synth_loop.sv
module synth_loop
  import synth_pkg::*;
#(
  parameter int unsigned W         = 14,
  parameter int unsigned MIN_RATIO = 5,
  parameter int unsigned WIDE_LIM  = 4,
  parameter int unsigned LOCK_CNT  = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         save,
  input  logic         vco_tick,
  input  logic [W-1:0] ratio,
  input  logic         cp_hi,
  input  logic         ref_ev,
  output logic         fb_ev,
  output logic         up,
  output logic         dn,
  output cp_amt_t      cp_units,
  output logic         lock
);

  localparam int unsigned WID_W = $clog2(WIDE_LIM + 1);
  localparam int unsigned GD_W  = $clog2(LOCK_CNT + 1);

  logic             run;
  logic             up_q, dn_q, up_n, dn_n;
  logic             active, wide;
  logic [WID_W-1:0] wid;
  logic [GD_W-1:0]  good;
  logic             bad_seen, lock_q;

  assign run = ~save;

  synth_divider #(.W(W), .MIN_RATIO(MIN_RATIO)) u_fb_div (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (run),
    .tick  (vco_tick),
    .ratio (ratio),
    .pulse (fb_ev)
  );

  // Tri-state phase-frequency detector.
  always_comb begin
    up_n = up_q | ref_ev;
    dn_n = dn_q | fb_ev;
    if (up_n && dn_n) begin
      up_n = 1'b0;
      dn_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || save) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_n;
      dn_q <= dn_n;
    end
  end

  // Lock monitor: pulse width and run of clean comparison intervals.
  assign active = up_q | dn_q;
  assign wide   = active && ((32'(wid) + 32'd1) >= 32'(WIDE_LIM));

  always_ff @(posedge clk) begin
    if (!rst_n || save) begin
      wid      <= '0;
      good     <= '0;
      bad_seen <= 1'b0;
      lock_q   <= 1'b0;
    end else begin
      wid <= active ? (wide ? wid : wid + 1'b1) : '0;
      if (wide) begin
        lock_q   <= 1'b0;
        good     <= '0;
        bad_seen <= 1'b1;
      end else if (ref_ev) begin
        bad_seen <= 1'b0;
        if (bad_seen) begin
          good   <= '0;
          lock_q <= 1'b0;
        end else begin
          good   <= (32'(good) >= 32'(LOCK_CNT)) ? good : good + 1'b1;
          lock_q <= lock_q | ((32'(good) + 32'd1) >= 32'(LOCK_CNT));
        end
      end
    end
  end

  assign up       = up_q;
  assign dn       = dn_q;
  assign lock     = lock_q;
  assign cp_units = cp_amount(cp_hi);

  assert_mutex_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_q && dn_q));

  assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    save |=> (!up_q && !dn_q && !lock_q));

  assert_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wide |=> !lock_q);

  assert_up_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_q) |-> $past(ref_ev));

  assert_lock_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(ref_ev));

  always_comb begin
    assert_cp_R5: assert (cp_units == cp_amt_t'(200) || cp_units == cp_amt_t'(400));
  end

endmodule

// File: rtl/dual_synth_core.sv
module dual_synth_core
  import synth_pkg::*;
#(
  parameter int unsigned REF_W     = 12,
  parameter int unsigned FB_W      = 14,
  parameter int unsigned MIN_RATIO = 5,
  parameter int unsigned WIDE_LIM  = 4,
  parameter int unsigned LOCK_CNT  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             tx_vco_tick,
  input  logic             rx_vco_tick,
  input  logic [REF_W-1:0] ref_ratio,
  input  logic [FB_W-1:0]  tx_ratio,
  input  logic [FB_W-1:0]  rx_ratio,
  input  logic             tx_cp_hi,
  input  logic             rx_cp_hi,
  input  logic             tx_save,
  input  logic             rx_save,
  output logic             osc_en,
  output logic             ref_div_out,
  output logic             tx_div_out,
  output logic             rx_div_out,
  output logic             tx_up,
  output logic             tx_dn,
  output logic [8:0]       tx_cp_units,
  output logic             tx_lock,
  output logic             rx_up,
  output logic             rx_dn,
  output logic [8:0]       rx_cp_units,
  output logic             rx_lock
);

  logic                 ref_ev;
  logic [NUM_LOOPS-1:0] save_v, tick_v, cph_v, fb_v, up_v, dn_v, lock_v;
  logic [FB_W-1:0]      ratio_v [NUM_LOOPS];
  cp_amt_t              cp_v    [NUM_LOOPS];

  // The shared oscillator stops only when both loops are saved.
  assign osc_en = ~(tx_save & rx_save);

  synth_divider #(.W(REF_W), .MIN_RATIO(MIN_RATIO)) u_ref_div (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (osc_en),
    .tick  (ref_tick),
    .ratio (ref_ratio),
    .pulse (ref_ev)
  );

  assign save_v[TX_IDX]  = tx_save;
  assign save_v[RX_IDX]  = rx_save;
  assign tick_v[TX_IDX]  = tx_vco_tick;
  assign tick_v[RX_IDX]  = rx_vco_tick;
  assign cph_v[TX_IDX]   = tx_cp_hi;
  assign cph_v[RX_IDX]   = rx_cp_hi;
  assign ratio_v[TX_IDX] = tx_ratio;
  assign ratio_v[RX_IDX] = rx_ratio;

  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
    synth_loop #(
      .W(FB_W), .MIN_RATIO(MIN_RATIO), .WIDE_LIM(WIDE_LIM), .LOCK_CNT(LOCK_CNT)
    ) u_loop (
      .clk      (clk),
      .rst_n    (rst_n),
      .save     (save_v[g]),
      .vco_tick (tick_v[g]),
      .ratio    (ratio_v[g]),
      .cp_hi    (cph_v[g]),
      .ref_ev   (ref_ev),
      .fb_ev    (fb_v[g]),
      .up       (up_v[g]),
      .dn       (dn_v[g]),
      .cp_units (cp_v[g]),
      .lock     (lock_v[g])
    );
  end

  assign ref_div_out = ref_ev;
  assign tx_div_out  = fb_v[TX_IDX];
  assign rx_div_out  = fb_v[RX_IDX];
  assign tx_up       = up_v[TX_IDX];
  assign tx_dn       = dn_v[TX_IDX];
  assign rx_up       = up_v[RX_IDX];
  assign rx_dn       = dn_v[RX_IDX];
  assign tx_lock     = lock_v[TX_IDX];
  assign rx_lock     = lock_v[RX_IDX];
  assign tx_cp_units = cp_v[TX_IDX];
  assign rx_cp_units = cp_v[RX_IDX];

  assert_osc_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> !ref_div_out);

  assert_save_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_save && rx_save) |=> (!tx_lock && !rx_lock));

endmodule

// File: tb/dual_synth_core_tb_top.sv
module dual_synth_core_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ref_tick, tx_vco_tick, rx_vco_tick;
  logic [11:0] ref_ratio;
  logic [13:0] tx_ratio, rx_ratio;
  logic        tx_cp_hi, rx_cp_hi, tx_save, rx_save;
  logic        osc_en, ref_div_out, tx_div_out, rx_div_out;
  logic        tx_up, tx_dn, tx_lock, rx_up, rx_dn, rx_lock;
  logic [8:0]  tx_cp_units, rx_cp_units;

  int checks = 0;
  int fails  = 0;
  int m_cnt [3];
  bit m_up [2];
  bit m_dn [2];

  always #5 clk = ~clk;

  dual_synth_core dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .tx_vco_tick(tx_vco_tick),
    .rx_vco_tick(rx_vco_tick), .ref_ratio(ref_ratio), .tx_ratio(tx_ratio),
    .rx_ratio(rx_ratio), .tx_cp_hi(tx_cp_hi), .rx_cp_hi(rx_cp_hi),
    .tx_save(tx_save), .rx_save(rx_save), .osc_en(osc_en),
    .ref_div_out(ref_div_out), .tx_div_out(tx_div_out), .rx_div_out(rx_div_out),
    .tx_up(tx_up), .tx_dn(tx_dn), .tx_cp_units(tx_cp_units), .tx_lock(tx_lock),
    .rx_up(rx_up), .rx_dn(rx_dn), .rx_cp_units(rx_cp_units), .rx_lock(rx_lock)
  );

  function automatic int eff(input int r);
    return (r > 4) ? r : 5;
  endfunction

  function automatic int cp_expect(input bit hi);
    return hi ? 400 : 200;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a falling edge after inputs are set; compares, advances the model, waits one cycle.
  task automatic step();
    bit osc, er, et, ex;
    bit ev [3];
    bit sv [2];
    #1;
    osc = !(tx_save && rx_save);
    er  = osc && ref_tick && (m_cnt[0] + 1 >= eff(int'(ref_ratio)));
    et  = !tx_save && tx_vco_tick && (m_cnt[1] + 1 >= eff(int'(tx_ratio)));
    ex  = !rx_save && rx_vco_tick && (m_cnt[2] + 1 >= eff(int'(rx_ratio)));
    check("R7 osc_en", osc_en, osc);
    check("R1 ref_div_out", ref_div_out, er);
    check("R2 tx_div_out", tx_div_out, et);
    check("R2 rx_div_out", rx_div_out, ex);
    check("R4 tx_up", tx_up, m_up[0]);
    check("R4 tx_dn", tx_dn, m_dn[0]);
    check("R4 rx_up", rx_up, m_up[1]);
    check("R4 rx_dn", rx_dn, m_dn[1]);
    check("R10 tx mutex", tx_up & tx_dn, 0);
    check("R10 rx mutex", rx_up & rx_dn, 0);
    check("R5 tx_cp_units", tx_cp_units, cp_expect(tx_cp_hi));
    check("R5 rx_cp_units", rx_cp_units, cp_expect(rx_cp_hi));
    ev[0] = er; ev[1] = et; ev[2] = ex;
    sv[0] = tx_save; sv[1] = rx_save;
    m_cnt[0] = !osc ? 0 : (er ? 0 : (ref_tick ? m_cnt[0] + 1 : m_cnt[0]));
    m_cnt[1] = tx_save ? 0 : (et ? 0 : (tx_vco_tick ? m_cnt[1] + 1 : m_cnt[1]));
    m_cnt[2] = rx_save ? 0 : (ex ? 0 : (rx_vco_tick ? m_cnt[2] + 1 : m_cnt[2]));
    for (int i = 0; i < 2; i++) begin
      bit nu, nd;
      nu = m_up[i] | er;
      nd = m_dn[i] | ev[i+1];
      if (sv[i] || (nu && nd)) begin
        nu = 0;
        nd = 0;
      end
      m_up[i] = nu;
      m_dn[i] = nd;
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ref_tick = 1; tx_vco_tick = 1; rx_vco_tick = 1;
    ref_ratio = 5; tx_ratio = 5; rx_ratio = 5;
    tx_cp_hi = 0; rx_cp_hi = 0; tx_save = 0; rx_save = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3; i++) m_cnt[i] = 0;
    for (int i = 0; i < 2; i++) begin m_up[i] = 0; m_dn[i] = 0; end
    rst_n = 1'b1;
  endtask

  // Cycles between two consecutive strobes of the chosen divider (0 ref, 1 tx, 2 rx).
  task automatic measure(input int which, output int gap);
    bit seen = 0;
    bit p;
    gap = 0;
    for (int n = 0; n < 40000; n++) begin
      #1;
      p = (which == 0) ? ref_div_out : ((which == 1) ? tx_div_out : rx_div_out);
      if (p) begin
        if (seen) break;
        seen = 1;
        gap = 0;
      end
      step();
      gap++;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int refs, hi_run, gap;
    void'($urandom(32'd2718));
    do_reset();

    // Reset state
    #1;
    check("R8 reset tx_lock", tx_lock, 0);
    check("R8 reset rx_lock", rx_lock, 0);
    check("R4 reset tx_up", tx_up, 0);
    check("R7 reset osc_en", osc_en, 1);

    // R8: aligned strobes, lock rises after 8th reference strobe
    refs = 0;
    for (int n = 0; n < 200 && refs < 8; n++) begin
      #1;
      if (ref_div_out) refs++;
      step();
      if (refs < 8) check("R8 tx lock early", tx_lock, 0);
      else begin
        check("R8 tx lock on 8th", tx_lock, 1);
        check("R8 rx lock on 8th", rx_lock, 1);
      end
    end

    // R9: stop transmit feedback; up pulse widens
    tx_vco_tick = 0;
    hi_run = 0;
    for (int n = 0; n < 100; n++) begin
      step();
      if (tx_up) hi_run++;
      if (hi_run == 4) check("R9 lock kept at 3-cycle pulse", tx_lock, 1);
      if (hi_run == 5) begin
        check("R9 lock dropped after 4th cycle", tx_lock, 0);
        check("R6 rx unaffected", rx_lock, 1);
        break;
      end
    end

    // R6/R7: power-save per loop, then both
    tx_save = 1;
    step();
    check("R6 tx_lock saved", tx_lock, 0);
    check("R6 tx_up saved", tx_up, 0);
    check("R6 rx_lock other loop", rx_lock, 1);
    rx_save = 1;
    step();
    check("R7 osc off", osc_en, 0);
    check("R6 rx_lock saved", rx_lock, 0);
    repeat (20) step();
    tx_save = 0; rx_save = 0;
    tx_cp_hi = 1;
    step();
    check("R5 tx high current", tx_cp_units, 400);

    // R1/R2: worked-example ratios
    do_reset();
    ref_ratio = 2048;
    measure(0, gap);
    check("R1 ref gap 2048", gap, 2048);
    rx_ratio = 7183;
    measure(2, gap);
    check("R2 rx gap 7183", gap, 7183);

    // R3: clamp below the floor
    do_reset();
    tx_ratio = 2;
    measure(1, gap);
    check("R3 tx ratio 2", gap, 5);
    tx_ratio = 0;
    measure(1, gap);
    check("R3 tx ratio 0", gap, 5);
    ref_ratio = 3;
    measure(0, gap);
    check("R3 ref ratio 3", gap, 5);

    // Random stimulus against the model
    do_reset();
    for (int k = 0; k < 4000; k++) begin
      if (k % 200 == 0) begin
        ref_ratio = 12'($urandom_range(0, 9));
        tx_ratio  = 14'($urandom_range(0, 9));
        rx_ratio  = 14'($urandom_range(0, 9));
        tx_cp_hi  = 1'($urandom_range(0, 1));
        rx_cp_hi  = 1'($urandom_range(0, 1));
      end
      if (k % 50 == 0) begin
        tx_save = ($urandom_range(0, 4) == 0);
        rx_save = ($urandom_range(0, 4) == 0);
      end
      ref_tick    = ($urandom_range(0, 3) != 0);
      tx_vco_tick = ($urandom_range(0, 3) != 0);
      rx_vco_tick = ($urandom_range(0, 3) != 0);
      step();
    end

    finish_run();
  end

endmodule